// File: doc/BRIEF.md
# Circular Interrupt Queue Writer

This block collects interrupt status words from several requesters inside a controller and writes each one into a ring of 32-bit entries in host memory. Each requester offers a word with a valid/ready handshake. The block takes one word at a time in fixed priority order and sets the top bit of the word as a marker. It then raises a word-wide write request towards memory and holds it until a grant comes back. When the grant arrives, the write pointer moves forward by one word and wraps at the end of the ring. One cycle after each completed write, the block pulses an interrupt output.

Software places the ring with a define-queue command that carries two configuration words. The first word is the ring's base byte address. The low 8 bits of the second word, N, set the ring length to (N+1) blocks of 16 words. The command loads both the base and the write pointer. While the base is zero, no ring is defined: the block still accepts offered words but throws them away without touching memory. Producers build their entries from fixed bit positions. An acknowledge entry sets bit 15. A frame-indication entry sets bit 12 and puts the channel number in bits 4:0.

Top module: `irq_queue_writer`

## Requirements
- R1: After reset, mem_req, irq_pulse and every post_ready bit are 0, the base is zero, and any post taken before the first define-queue command is dropped.
- R2: Every word written to memory has bit 31 set to 1. Bits 30:0 equal the offered word, so an acknowledge entry 0x0000_8000 is written as 0x8000_8000 and a frame entry for channel 5 (0x0000_1005) is written as 0x8000_1005.
- R3: After a define-queue command with a nonzero base B, the next entry is written at byte address B.
- R4: Each completed write moves the write pointer forward by 4 bytes.
- R5: When the advanced pointer reaches or passes B + (N+1)*64, it returns to B. N is bits 7:0 of the size word, and bits 31:8 of that word have no effect.
- R6: While the base is zero, a post is accepted (its ready bit is 1) and discarded: no mem_req and no irq_pulse follow.
- R7: When several requesters are valid at once, only the lowest-numbered one sees ready. At most one ready bit is 1, and no ready bit is 1 while a write is outstanding.
- R8: Once raised, mem_req stays high with mem_addr and mem_wdata unchanged until the cycle mem_gnt is sampled high, unless a define-queue command intervenes.
- R9: irq_pulse is high for exactly one cycle, the cycle after each write completes (mem_req and mem_gnt both high).
- R10: A define-queue command that arrives while an entry is still waiting for its grant redirects that entry to the new base. If the new base is zero, the waiting entry is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| define_valid | input | 1 | One-cycle define-queue command |
| define_base | input | ADDR_W | Ring base byte address (zero = no ring) |
| define_size | input | DATA_W | Size configuration word; bits 7:0 give N |
| post_valid | input | NUM_SRC | Per-requester valid |
| post_data | input | NUM_SRC*DATA_W | Per-requester status word, requester i in slice i |
| post_ready | output | NUM_SRC | Per-requester ready (word taken this cycle) |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Byte address of the write |
| mem_wdata | output | DATA_W | Entry written |
| mem_gnt | input | 1 | Memory grant; the write completes when mem_req and mem_gnt are both high |
| irq_pulse | output | 1 | One-cycle pulse after each completed write |

## Verification
The hardest situation to reach is a define-queue command that lands while an entry sits waiting for its grant. It must either move that entry to the new base or drop it when the new base is zero. The bench reaches it by holding mem_gnt low, posting a word so that a request is left pending, and then issuing the command before releasing the grant. Wrap-around is reached by posting exactly one ring's worth of entries, for both a one-block ring and a two-block ring, and checking the address of the entry that follows.

// File: rtl/irqq_pkg.sv
package irqq_pkg;
   localparam int unsigned IRQQ_ACK_BIT     = 15;
   localparam int unsigned IRQQ_FRAME_BIT   = 12;
   localparam int unsigned IRQQ_CHAN_W      = 5;
   localparam int unsigned IRQQ_UNIT_WORDS  = 16;

   function automatic logic [31:0] irqq_ack_entry();
      logic [31:0] e;
      e = '0;
      e[IRQQ_ACK_BIT] = 1'b1;
      return e;
   endfunction

   function automatic logic [31:0] irqq_frame_entry(input logic [IRQQ_CHAN_W-1:0] ch);
      logic [31:0] e;
      e = '0;
      e[IRQQ_FRAME_BIT] = 1'b1;
      e[IRQQ_CHAN_W-1:0] = ch;
      return e;
   endfunction
endpackage

// File: rtl/irqq_arbiter.sv
module irqq_arbiter #(
   parameter int unsigned NUM_SRC = 4
) (
   input  logic [NUM_SRC-1:0] req,
   output logic [NUM_SRC-1:0] grant
);
   logic [NUM_SRC:0] seen;

   assign seen[0] = 1'b0;
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_pri
      assign grant[i]  = req[i] & ~seen[i];
      assign seen[i+1] = seen[i] | req[i];
   end
endmodule

// File: rtl/irqq_pointer.sv
module irqq_pointer #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned SIZE_W     = 8,
   parameter int unsigned UNIT_WORDS = 16,
   parameter int unsigned WORD_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_base,
   input  logic [SIZE_W-1:0] load_units,
   input  logic              advance,
   output logic [ADDR_W-1:0] wr_ptr,
   output logic              base_nz
);
   localparam int unsigned UNIT_BYTES = UNIT_WORDS * WORD_BYTES;

   logic [ADDR_W-1:0] base_q, end_q, ptr_q;
   logic [ADDR_W-1:0] ring_len, ptr_inc;

   assign ring_len = ADDR_W'((32'(load_units) + 32'd1) * UNIT_BYTES);
   assign ptr_inc  = ptr_q + ADDR_W'(WORD_BYTES);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         end_q  <= '0;
         ptr_q  <= '0;
      end else if (load) begin
         base_q <= load_base;
         end_q  <= load_base + ring_len;
         ptr_q  <= load_base;
      end else if (advance) begin
         ptr_q  <= (ptr_inc >= end_q) ? base_q : ptr_inc;
      end
   end

   assign wr_ptr  = ptr_q;
   assign base_nz = |base_q;
endmodule

// File: rtl/irq_queue_writer.sv
module irq_queue_writer #(
   parameter int unsigned NUM_SRC = 4,
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned SIZE_W  = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      define_valid,
   input  logic [ADDR_W-1:0]         define_base,
   input  logic [DATA_W-1:0]         define_size,
   input  logic [NUM_SRC-1:0]        post_valid,
   input  logic [NUM_SRC*DATA_W-1:0] post_data,
   output logic [NUM_SRC-1:0]        post_ready,
   output logic                      mem_req,
   output logic [ADDR_W-1:0]         mem_addr,
   output logic [DATA_W-1:0]         mem_wdata,
   input  logic                      mem_gnt,
   output logic                      irq_pulse
);
   import irqq_pkg::*;

   localparam int unsigned WORD_BYTES = DATA_W / 8;
   localparam int unsigned MARK_BIT   = DATA_W - 1;

   if (NUM_SRC < 1) begin : g_bad_src
      $error("NUM_SRC must be at least 1");
   end
   if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_bad_data
      $error("DATA_W must be a whole number of bytes and at least 16");
   end
   if (SIZE_W > DATA_W || SIZE_W + 8 > ADDR_W) begin : g_bad_size
      $error("SIZE_W does not fit the data or address width");
   end

   logic                busy_q, irq_q;
   logic [DATA_W-1:0]   held_q;
   logic [NUM_SRC-1:0]  grant;
   logic [DATA_W-1:0]   chosen;
   logic [ADDR_W-1:0]   wr_ptr;
   logic                base_nz, base_ok, take, done, kill;

   irqq_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
      .req   (post_valid & {NUM_SRC{~busy_q}}),
      .grant (grant)
   );

   always_comb begin
      chosen = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (grant[i]) chosen = post_data[i*DATA_W +: DATA_W];
      end
   end

   irqq_pointer #(
      .ADDR_W     (ADDR_W),
      .SIZE_W     (SIZE_W),
      .UNIT_WORDS (IRQQ_UNIT_WORDS),
      .WORD_BYTES (WORD_BYTES)
   ) u_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (define_valid),
      .load_base  (define_base),
      .load_units (define_size[SIZE_W-1:0]),
      .advance    (done),
      .wr_ptr     (wr_ptr),
      .base_nz    (base_nz)
   );

   assign base_ok = define_valid ? (|define_base) : base_nz;
   assign take    = (|grant) & base_ok;
   assign done    = busy_q & mem_gnt;
   assign kill    = define_valid & ~(|define_base);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         held_q <= '0;
         irq_q  <= 1'b0;
      end else begin
         irq_q <= done;
         if (take) begin
            busy_q <= 1'b1;
            held_q <= chosen | (DATA_W'(1) << MARK_BIT);
         end else if (done || kill) begin
            busy_q <= 1'b0;
         end
      end
   end

   assign post_ready = grant;
   assign mem_req    = busy_q;
   assign mem_addr   = wr_ptr;
   assign mem_wdata  = held_q;
   assign irq_pulse  = irq_q;
endmodule

// File: rtl/irqq_checker.sv
module irqq_checker #(
   parameter int unsigned NUM_SRC = 4,
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned DATA_W  = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               define_valid,
   input logic [NUM_SRC-1:0] post_ready,
   input logic               mem_req,
   input logic [ADDR_W-1:0]  mem_addr,
   input logic [DATA_W-1:0]  mem_wdata,
   input logic               mem_gnt,
   input logic               irq_pulse
);
   AST_MARK_SET: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_wdata[DATA_W-1]); // R2
   AST_ADDR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr != '0)); // R6
   AST_ONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(post_ready)); // R7
   AST_NO_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (post_ready == '0)); // R7
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt && !define_valid) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata))); // R8
   AST_IRQ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_gnt) |=> irq_pulse); // R9
   AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |=> !irq_pulse); // R9
endmodule

bind irq_queue_writer irqq_checker #(
   .NUM_SRC (NUM_SRC),
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .define_valid (define_valid),
   .post_ready   (post_ready),
   .mem_req      (mem_req),
   .mem_addr     (mem_addr),
   .mem_wdata    (mem_wdata),
   .mem_gnt      (mem_gnt),
   .irq_pulse    (irq_pulse)
);

// File: tb/irq_queue_writer_test.sv
module irq_queue_writer_test;
   localparam int NS = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            define_valid = 1'b0;
   logic [31:0]     define_base = '0;
   logic [31:0]     define_size = '0;
   logic [NS-1:0]   post_valid = '0;
   logic [NS*32-1:0] post_data = '0;
   logic [NS-1:0]   post_ready;
   logic            mem_req;
   logic [31:0]     mem_addr, mem_wdata;
   logic            mem_gnt = 1'b1;
   logic            irq_pulse;

   int checks = 0, errors = 0;
   int wr_cnt = 0, irq_cnt = 0;
   logic [31:0] wr_addr [0:127];
   logic [31:0] wr_data [0:127];

   always #4 clk = ~clk;

   irq_queue_writer #(.NUM_SRC(NS)) uut (
      .clk(clk), .rst_n(rst_n), .define_valid(define_valid),
      .define_base(define_base), .define_size(define_size),
      .post_valid(post_valid), .post_data(post_data), .post_ready(post_ready),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_gnt(mem_gnt), .irq_pulse(irq_pulse)
   );

   always @(posedge clk) begin
      if (rst_n && mem_req && mem_gnt) begin
         wr_addr[wr_cnt % 128] <= mem_addr;
         wr_data[wr_cnt % 128] <= mem_wdata;
         wr_cnt <= wr_cnt + 1;
      end
      if (rst_n && irq_pulse) irq_cnt <= irq_cnt + 1;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic define_q(input logic [31:0] b, input logic [31:0] s);
      @(negedge clk);
      define_valid = 1'b1; define_base = b; define_size = s;
      @(posedge clk);
      @(negedge clk);
      define_valid = 1'b0;
   endtask

   // drives queued valid bits until each has been taken
   task automatic drain(input int max_cycles);
      for (int c = 0; c < max_cycles && post_valid != '0; c++) begin
         logic [NS-1:0] rr;
         #1 rr = post_ready;
         @(posedge clk);
         @(negedge clk);
         post_valid = post_valid & ~rr;
      end
   endtask

   task automatic post(input int src, input logic [31:0] w);
      @(negedge clk);
      post_data[src*32 +: 32] = w;
      post_valid[src] = 1'b1;
      drain(50);
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset;
      #1;
      chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
      chk("R1 irq", {31'd0, irq_pulse}, 32'd0);
      chk("R1 ready", {28'd0, post_ready}, 32'd0);
   endtask

   task automatic t_zero_base;
      int w0 = wr_cnt, i0 = irq_cnt;
      logic seen;
      @(negedge clk);
      post_data[31:0] = 32'h0000_8000;
      post_valid[0] = 1'b1;
      #1 seen = post_ready[0];
      @(posedge clk); @(negedge clk);
      post_valid[0] = 1'b0;
      repeat (4) @(negedge clk);
      chk("R6 accepted", {31'd0, seen}, 32'd1);
      chk("R6 no write", wr_cnt - w0, 0);
      chk("R1 R6 no irq", irq_cnt - i0, 0);
   endtask

   task automatic t_first_posts;
      int w0, i0;
      define_q(32'h0000_1000, 32'h0000_0000);
      w0 = wr_cnt; i0 = irq_cnt;
      post(0, irqq_pkg::irqq_ack_entry());
      post(2, irqq_pkg::irqq_frame_entry(5'd5));
      post(1, 32'h8000_0001);
      chk("R3 first addr", wr_addr[w0 % 128], 32'h0000_1000);
      chk("R2 ack entry", wr_data[w0 % 128], 32'h8000_8000);
      chk("R4 second addr", wr_addr[(w0+1) % 128], 32'h0000_1004);
      chk("R2 frame entry", wr_data[(w0+1) % 128], 32'h8000_1005);
      chk("R4 third addr", wr_addr[(w0+2) % 128], 32'h0000_1008);
      chk("R2 marker kept", wr_data[(w0+2) % 128], 32'h8000_0001);
      chk("R9 irq per write", irq_cnt - i0, 3);
   endtask

   task automatic t_wrap(input logic [31:0] b, input logic [31:0] s, input int entries, input string tag);
      int w0;
      define_q(b, s);
      w0 = wr_cnt;
      for (int k = 0; k <= entries; k++) post(k % NS, k);
      chk({tag, " last addr"}, wr_addr[(w0+entries-1) % 128], b + 4*(entries-1));
      chk({tag, " wrap addr"}, wr_addr[(w0+entries) % 128], b);
   endtask

   task automatic t_priority;
      int w0 = wr_cnt;
      logic [NS-1:0] r;
      @(negedge clk);
      mem_gnt = 1'b0;
      post_data[32 +: 32] = 32'h11; post_data[64 +: 32] = 32'h22; post_data[96 +: 32] = 32'h33;
      post_valid = 4'b1110;
      #1 r = post_ready;
      chk("R7 lowest wins", {28'd0, r}, 32'h2);
      @(posedge clk); @(negedge clk);
      post_valid = post_valid & ~r;
      #1 chk("R7 no ready while busy", {28'd0, post_ready}, 32'h0);
      @(negedge clk);
      mem_gnt = 1'b1;
      drain(50);
      repeat (3) @(negedge clk);
      chk("R7 order 1", wr_data[w0 % 128], 32'h8000_0011);
      chk("R7 order 2", wr_data[(w0+1) % 128], 32'h8000_0022);
      chk("R7 order 3", wr_data[(w0+2) % 128], 32'h8000_0033);
   endtask

   task automatic t_stall_and_redefine;
      int w0, i0;
      logic [31:0] a0;
      @(negedge clk);
      mem_gnt = 1'b0;
      post_data[31:0] = 32'h0000_0077;
      post_valid[0] = 1'b1;
      @(posedge clk); @(negedge clk);
      post_valid[0] = 1'b0;
      a0 = mem_addr; w0 = wr_cnt; i0 = irq_cnt;
      repeat (4) @(negedge clk);
      chk("R8 req held", {31'd0, mem_req}, 32'd1);
      chk("R8 addr held", mem_addr, a0);
      chk("R9 no irq while stalled", irq_cnt - i0, 0);
      define_q(32'h0000_3000, 32'h0000_0000);
      mem_gnt = 1'b1;
      repeat (4) @(negedge clk);
      chk("R10 redirected addr", wr_addr[w0 % 128], 32'h0000_3000);
      chk("R10 redirected data", wr_data[w0 % 128], 32'h8000_0077);
      mem_gnt = 1'b0;
      post(3, 32'h0000_0099);
      w0 = wr_cnt;
      define_q(32'h0, 32'h0);
      mem_gnt = 1'b1;
      repeat (5) @(negedge clk);
      chk("R10 dropped on zero base", wr_cnt - w0, 0);
      chk("R6 idle after drop", {31'd0, mem_req}, 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_zero_base();
      t_first_posts();
      t_wrap(32'h0000_1000, 32'hABCD_0100, 16, "R5 one block");
      t_wrap(32'h0000_2000, 32'h0000_0001, 32, "R5 two blocks");
      t_priority();
      t_stall_and_redefine();
      chk("R9 irq count", irq_cnt, wr_cnt);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #1_000_000;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule